// File: doc/BRIEF.md
# PROM Adaptive Programming Pulse Sequencer

This block burns one byte into a fusible PROM socket. A start request captures the byte to be written. The block then repeats a fixed power-and-pulse cycle. Each cycle deselects the socket, loads the byte into the programmer latches, powers the supplies, fires one program pulse, powers down, reselects the socket for reading and samples the data bus. Cycles repeat until the byte read back equals the byte requested. The number of cycles this took, N, is kept.

Once the byte matches, the block adds 5×N further cycles to give the fuses margin. During these cycles the sampled data has no effect. The block then reports done. If the byte has still not matched after the attempt cap, the block stops and reports a bad PROM instead. All waiting intervals are parameters counted in clock cycles. Every strobe leaves a flip-flop. Stepping the address counter and looping over a whole device belong to the surrounding logic.

Top module: `prom_pulse_seq`

## Requirements
- R1: Each pulse cycle first drops read mode and chip select. Next comes a one-cycle latch-load strobe carrying the target byte, given while the socket is deselected and the supplies are off. Only after that strobe does the supply enable rise. The program pulse is high only while the supply is enabled, and the supply is enabled only while read mode and chip select are both low.
- R2: The program pulse rises exactly T_SETUP cycles after the supply enable rises, and it stays high for exactly T_PULSE cycles.
- R3: The supply enable falls exactly T_HOLD cycles after the program pulse falls. Read mode and chip select rise together exactly T_RECOVER cycles after the supply enable falls.
- R4: When read mode and chip select are restored, a one-cycle latch-load strobe with latch data 0x00 clears the programmer latches. The PROM data bus is sampled in the cycle after that strobe.
- R5: The attempt phase ends at the first sample equal to the target byte. The pulse-count output then reports N, the number of pulses issued up to that point.
- R6: If MAX_TRIES (default 254) samples in a row fail to match, fail_o goes high, the count reports MAX_TRIES, and no further pulse or supply activity occurs. done_o and fail_o are never high together.
- R7: After a match with N pulses, exactly 5×N further pulse cycles run, counted with a 16-bit counter, and done_o then goes high. The total pulse count for the byte is therefore 6×N.
- R8: Data sampled during the extra cycles is ignored. Read-back values that differ from the target change neither the number of extra cycles nor the outcome.
- R9: In reset, all strobes, done_o and fail_o are low, the latch data is 0x00 and the pulse count is 0.
- R10: done_o and fail_o stay high until the next start. That start clears them and begins a new byte with a count of zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin programming; accepted when idle or finished |
| target_i | input | 8 | Byte to program, captured on start |
| prom_data_i | input | 8 | Data bus read from the PROM socket |
| supply_en_o | output | 1 | Enables the programming supply voltages |
| pulse_o | output | 1 | Program pulse |
| read_mode_o | output | 1 | Places the programmer in read mode |
| chip_sel_o | output | 1 | Selects the PROM socket |
| latch_load_o | output | 1 | One-cycle strobe writing latch_data_o into the programmer latches |
| latch_data_o | output | 8 | Data for the programmer latches |
| done_o | output | 1 | Byte programmed and over-programmed |
| fail_o | output | 1 | Byte could not be programmed within the cap |
| pulses_o | output | 8 | Attempt-phase pulse count N |

## Verification
The hardest case to reach is the attempt cap. A match on exactly the last permitted pulse must succeed, and one pulse fewer of tolerance must fail. The bench has a PROM model whose fuses answer only after a chosen number of pulses. Setting that number to the cap, and to never, takes the block to both sides of the boundary. The model can also return scrambled data once the byte has matched. This shows that the over-programming tally is unaffected by what the bus says.

// File: rtl/prom_seq_pkg.sv
package prom_seq_pkg;

    localparam int DATA_W = 8;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_DROP,
        ST_LOAD,
        ST_SETUP,
        ST_PULSE,
        ST_HOLD,
        ST_RECOVER,
        ST_RESTORE,
        ST_SAMPLE,
        ST_DONE,
        ST_FAIL
    } seq_state_e;

    typedef enum logic {
        PH_ATTEMPT,
        PH_OVER
    } seq_phase_e;

    typedef struct packed {
        seq_state_e          state;
        seq_phase_e          phase;
        logic [DATA_W-1:0]   target;
        logic [DATA_W-1:0]   latch_data;
        logic                supply;
        logic                pulse;
        logic                rd;
        logic                cs;
        logic                ld;
        logic                done;
        logic                fail;
    } seq_regs_t;

endpackage

// File: rtl/prom_seq_timer.sv
module prom_seq_timer #(
    parameter int TMR_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [TMR_W-1:0] value_i,
    output logic             expired_o
);

    logic [TMR_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load_i) begin
            cnt_d = value_i;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign expired_o = (cnt_q == '0);

endmodule

// File: rtl/prom_seq_count.sv
module prom_seq_count #(
    parameter int CNT_W  = 8,
    parameter int OVER_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear_i,
    input  logic              inc_i,
    input  logic              arm_i,
    input  logic              dec_i,
    output logic [CNT_W-1:0]  attempts_o,
    output logic [OVER_W-1:0] remaining_o
);

    logic [CNT_W-1:0]  att_d, att_q;
    logic [OVER_W-1:0] rem_d, rem_q;
    logic [OVER_W-1:0] att_ext;

    always_comb begin
        att_d   = att_q + CNT_W'(inc_i);
        att_ext = OVER_W'(att_d);
        rem_d   = rem_q;
        if (arm_i) begin
            rem_d = (att_ext << 2) + att_ext;
        end else if (dec_i && rem_q != '0) begin
            rem_d = rem_q - 1'b1;
        end
        if (clear_i) begin
            att_d = '0;
            rem_d = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            att_q <= '0;
            rem_q <= '0;
        end else begin
            att_q <= att_d;
            rem_q <= rem_d;
        end
    end

    assign attempts_o  = att_q;
    assign remaining_o = rem_q;

endmodule

// File: rtl/prom_pulse_seq.sv
module prom_pulse_seq
    import prom_seq_pkg::*;
#(
    parameter int T_SETUP   = 4000,
    parameter int T_PULSE   = 8000,
    parameter int T_HOLD    = 800,
    parameter int T_RECOVER = 800,
    parameter int MAX_TRIES = 254,
    parameter int OVER_W    = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start_i,
    input  logic [DATA_W-1:0]    target_i,
    input  logic [DATA_W-1:0]    prom_data_i,
    output logic                 supply_en_o,
    output logic                 pulse_o,
    output logic                 read_mode_o,
    output logic                 chip_sel_o,
    output logic                 latch_load_o,
    output logic [DATA_W-1:0]    latch_data_o,
    output logic                 done_o,
    output logic                 fail_o,
    output logic [$clog2(MAX_TRIES+1)-1:0] pulses_o
);

    localparam int CNT_W   = $clog2(MAX_TRIES + 1);
    localparam int MAX_AB  = (T_SETUP > T_PULSE) ? T_SETUP : T_PULSE;
    localparam int MAX_CD  = (T_HOLD > T_RECOVER) ? T_HOLD : T_RECOVER;
    localparam int DLY_MAX = (MAX_AB > MAX_CD) ? MAX_AB : MAX_CD;
    localparam int TMR_W   = $clog2(DLY_MAX + 1);

    seq_regs_t          d, q;
    logic               tmr_load;
    logic [TMR_W-1:0]   tmr_val;
    logic               tmr_expired;
    logic               cnt_clear, cnt_inc, cnt_arm, cnt_dec;
    logic [CNT_W-1:0]   attempts;
    logic [OVER_W-1:0]  remaining;
    logic               readback_ok;
    logic               cap_reached;
    logic               last_extra;

    prom_seq_timer #(.TMR_W(TMR_W)) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_i    (tmr_load),
        .value_i   (tmr_val),
        .expired_o (tmr_expired)
    );

    prom_seq_count #(.CNT_W(CNT_W), .OVER_W(OVER_W)) u_count (
        .clk         (clk),
        .rst_n       (rst_n),
        .clear_i     (cnt_clear),
        .inc_i       (cnt_inc),
        .arm_i       (cnt_arm),
        .dec_i       (cnt_dec),
        .attempts_o  (attempts),
        .remaining_o (remaining)
    );

    assign readback_ok = (prom_data_i == q.target);
    assign cap_reached = (attempts == CNT_W'(MAX_TRIES - 1));
    assign last_extra  = (remaining == OVER_W'(1));

    always_comb begin
        d         = q;
        d.ld      = 1'b0;
        tmr_load  = 1'b0;
        tmr_val   = '0;
        cnt_clear = 1'b0;
        cnt_inc   = 1'b0;
        cnt_arm   = 1'b0;
        cnt_dec   = 1'b0;

        unique case (q.state)
            ST_IDLE, ST_DONE, ST_FAIL: begin
                if (start_i) begin
                    d.state  = ST_DROP;
                    d.phase  = PH_ATTEMPT;
                    d.target = target_i;
                    d.done   = 1'b0;
                    d.fail   = 1'b0;
                    d.rd     = 1'b0;
                    d.cs     = 1'b0;
                    cnt_clear = 1'b1;
                end
            end
            ST_DROP: begin
                d.state      = ST_LOAD;
                d.ld         = 1'b1;
                d.latch_data = q.target;
            end
            ST_LOAD: begin
                d.state  = ST_SETUP;
                d.supply = 1'b1;
                tmr_load = 1'b1;
                tmr_val  = TMR_W'(T_SETUP - 1);
            end
            ST_SETUP: begin
                if (tmr_expired) begin
                    d.state  = ST_PULSE;
                    d.pulse  = 1'b1;
                    tmr_load = 1'b1;
                    tmr_val  = TMR_W'(T_PULSE - 1);
                end
            end
            ST_PULSE: begin
                if (tmr_expired) begin
                    d.state  = ST_HOLD;
                    d.pulse  = 1'b0;
                    tmr_load = 1'b1;
                    tmr_val  = TMR_W'(T_HOLD - 1);
                end
            end
            ST_HOLD: begin
                if (tmr_expired) begin
                    d.state  = ST_RECOVER;
                    d.supply = 1'b0;
                    tmr_load = 1'b1;
                    tmr_val  = TMR_W'(T_RECOVER - 1);
                end
            end
            ST_RECOVER: begin
                if (tmr_expired) begin
                    d.state      = ST_RESTORE;
                    d.rd         = 1'b1;
                    d.cs         = 1'b1;
                    d.ld         = 1'b1;
                    d.latch_data = '0;
                end
            end
            ST_RESTORE: begin
                d.state = ST_SAMPLE;
            end
            ST_SAMPLE: begin
                d.rd = 1'b0;
                d.cs = 1'b0;
                if (q.phase == PH_ATTEMPT) begin
                    cnt_inc = 1'b1;
                    if (readback_ok) begin
                        cnt_arm = 1'b1;
                        d.phase = PH_OVER;
                        d.state = ST_DROP;
                    end else if (cap_reached) begin
                        d.state = ST_FAIL;
                        d.fail  = 1'b1;
                    end else begin
                        d.state = ST_DROP;
                    end
                end else begin
                    if (last_extra) begin
                        d.state = ST_DONE;
                        d.done  = 1'b1;
                    end else begin
                        cnt_dec = 1'b1;
                        d.state = ST_DROP;
                    end
                end
            end
            default: begin
                d.state = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{state: ST_IDLE, phase: PH_ATTEMPT, target: '0,
                   latch_data: '0, supply: 1'b0, pulse: 1'b0, rd: 1'b0,
                   cs: 1'b0, ld: 1'b0, done: 1'b0, fail: 1'b0};
        end else begin
            q <= d;
        end
    end

    assign supply_en_o  = q.supply;
    assign pulse_o      = q.pulse;
    assign read_mode_o  = q.rd;
    assign chip_sel_o   = q.cs;
    assign latch_load_o = q.ld;
    assign latch_data_o = q.latch_data;
    assign done_o       = q.done;
    assign fail_o       = q.fail;
    assign pulses_o     = attempts;

endmodule

// File: rtl/prom_pulse_seq_chk.sv
module prom_pulse_seq_chk #(
    parameter int MAX_TRIES = 254,
    parameter int CNT_W     = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start_i,
    input logic             supply_en_o,
    input logic             pulse_o,
    input logic             read_mode_o,
    input logic             chip_sel_o,
    input logic             latch_load_o,
    input logic             done_o,
    input logic             fail_o,
    input logic [CNT_W-1:0] pulses_o
);

    AST_PULSE_UNDER_SUPPLY: assert property (@(posedge clk) disable iff (!rst_n)
        pulse_o |-> supply_en_o); // R1
    AST_SUPPLY_SOCKET_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        supply_en_o |-> (!read_mode_o && !chip_sel_o)); // R1
    AST_LOAD_UNPOWERED: assert property (@(posedge clk) disable iff (!rst_n)
        latch_load_o |-> !supply_en_o); // R1
    AST_PULSE_AFTER_SETTLE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pulse_o) |-> $past(supply_en_o)); // R2
    AST_SUPPLY_AFTER_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(supply_en_o) |-> $past(!pulse_o)); // R3
    AST_RESULT_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(done_o && fail_o)); // R6
    AST_TRY_CAP: assert property (@(posedge clk) disable iff (!rst_n)
        32'(pulses_o) <= MAX_TRIES); // R6
    AST_QUIET_AFTER_FAIL: assert property (@(posedge clk) disable iff (!rst_n)
        fail_o |-> (!supply_en_o && !pulse_o)); // R6
    AST_DONE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !start_i) |=> done_o); // R10
    AST_FAIL_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (fail_o && !start_i) |=> fail_o); // R10

endmodule

bind prom_pulse_seq prom_pulse_seq_chk #(
    .MAX_TRIES (MAX_TRIES),
    .CNT_W     ($clog2(MAX_TRIES + 1))
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_i      (start_i),
    .supply_en_o  (supply_en_o),
    .pulse_o      (pulse_o),
    .read_mode_o  (read_mode_o),
    .chip_sel_o   (chip_sel_o),
    .latch_load_o (latch_load_o),
    .done_o       (done_o),
    .fail_o       (fail_o),
    .pulses_o     (pulses_o)
);

// File: tb/prom_pulse_seq_test.sv
module prom_pulse_seq_test;

    localparam int TS = 3, TP = 5, TH = 2, TR = 2, CAP = 254;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_i = 1'b0;
    logic [7:0] target_i = 8'h00;
    logic [7:0] prom_data_i;
    logic       supply_en_o, pulse_o, read_mode_o, chip_sel_o, latch_load_o;
    logic [7:0] latch_data_o;
    logic       done_o, fail_o;
    logic [7:0] pulses_o;

    always #4 clk = ~clk;

    prom_pulse_seq #(.T_SETUP(TS), .T_PULSE(TP), .T_HOLD(TH), .T_RECOVER(TR),
                     .MAX_TRIES(CAP)) uut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .target_i(target_i),
        .prom_data_i(prom_data_i), .supply_en_o(supply_en_o), .pulse_o(pulse_o),
        .read_mode_o(read_mode_o), .chip_sel_o(chip_sel_o),
        .latch_load_o(latch_load_o), .latch_data_o(latch_data_o),
        .done_o(done_o), .fail_o(fail_o), .pulses_o(pulses_o)
    );

    typedef struct { bit fail; int n; int total; } exp_t;
    exp_t sb_q[$];

    int checks = 0, errors = 0;
    bit finished = 0;

    // PROM model state
    int  pulse_cnt = 0;
    int  base = 0;
    int  need_k = 1;
    bit  scramble = 0;
    logic [7:0] tgt_cur = 8'h00;
    logic [7:0] model_val;

    always_comb begin
        int np;
        np = pulse_cnt - base;
        if (need_k == 0 || np < need_k) model_val = tgt_cur ^ 8'h01;
        else if (scramble && np > need_k) model_val = tgt_cur ^ 8'hA5;
        else model_val = tgt_cur;
    end
    assign prom_data_i = (read_mode_o && chip_sel_o) ? model_val : 8'h00;

    task automatic chk(bit ok, string req, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("== %0d vectors applied, %0d miscompares ==", checks, errors);
            $finish;
        end
    endtask

    // timing and strobe monitor
    int  cyc = 0;
    int  t_sup_on = 0, t_p_on = 0, t_p_off = 0, t_sup_off = 0;
    bit  p_sup = 0, p_pul = 0, p_rd = 0, p_res = 0;
    bit  armed = 0;

    always @(negedge clk) begin
        cyc++;
        if (rst_n) begin
            if (latch_load_o) begin
                if (!read_mode_o) begin
                    chk(latch_data_o == tgt_cur && !chip_sel_o && !supply_en_o,
                        "R1 target load while socket off", latch_data_o, tgt_cur);
                    armed = 1;
                end else begin
                    chk(latch_data_o == 8'h00 && chip_sel_o,
                        "R4 latch clear on restore", latch_data_o, 0);
                end
            end
            if (supply_en_o && !p_sup) begin
                chk(armed, "R1 latch load before supply", armed, 1);
                armed = 0;
                t_sup_on = cyc;
            end
            if (pulse_o && !p_pul) begin
                pulse_cnt++;
                t_p_on = cyc;
                chk(cyc - t_sup_on == TS, "R2 setup interval", cyc - t_sup_on, TS);
            end
            if (!pulse_o && p_pul) begin
                t_p_off = cyc;
                chk(cyc - t_p_on == TP, "R2 pulse width", cyc - t_p_on, TP);
            end
            if (!supply_en_o && p_sup) begin
                t_sup_off = cyc;
                chk(cyc - t_p_off == TH, "R3 hold interval", cyc - t_p_off, TH);
            end
            if (read_mode_o && !p_rd) begin
                chk(cyc - t_sup_off == TR && chip_sel_o, "R3 recover interval",
                    cyc - t_sup_off, TR);
            end
            if ((done_o || fail_o) && !p_res) begin
                exp_t e;
                if (sb_q.size() == 0) begin
                    chk(0, "R5 unexpected result", 1, 0);
                end else begin
                    e = sb_q.pop_front();
                    chk(fail_o == e.fail, "R6 outcome kind", fail_o, e.fail);
                    chk(int'(pulses_o) == e.n, "R5 pulse count N", pulses_o, e.n);
                    chk(pulse_cnt - base == e.total, "R7 R8 total pulses",
                        pulse_cnt - base, e.total);
                end
            end
        end
        p_sup = supply_en_o;
        p_pul = pulse_o;
        p_rd  = read_mode_o;
        p_res = done_o || fail_o;
    end

    task automatic run_byte(logic [7:0] tgt, int k, bit scr);
        exp_t e;
        int   snap;
        e.fail  = (k == 0 || k > CAP);
        e.n     = e.fail ? CAP : k;
        e.total = e.fail ? CAP : 6 * k;
        sb_q.push_back(e);
        @(negedge clk);
        tgt_cur  = tgt;
        need_k   = k;
        scramble = scr;
        base     = pulse_cnt;
        target_i = tgt;
        start_i  = 1'b1;
        @(negedge clk);
        start_i  = 1'b0;
        @(negedge clk);
        chk(!done_o && !fail_o, "R10 start clears result", done_o | fail_o, 0);
        while (!(done_o || fail_o)) @(negedge clk);
        snap = pulse_cnt;
        repeat (20) @(negedge clk);
        chk(done_o != fail_o, "R10 result held", done_o | fail_o, 1);
        chk(pulse_cnt == snap && !supply_en_o, "R6 quiet after finish",
            pulse_cnt, snap);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(!supply_en_o && !pulse_o && !read_mode_o && !chip_sel_o && !latch_load_o,
            "R9 strobes low in reset", supply_en_o, 0);
        chk(!done_o && !fail_o && pulses_o == 0 && latch_data_o == 0,
            "R9 results clear in reset", pulses_o, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk(!supply_en_o && !done_o && !fail_o, "R9 idle after reset", supply_en_o, 0);
        run_byte(8'h3C, 1, 0);     // R5 R7 single pulse
        run_byte(8'hA5, 3, 1);     // R8 scrambled extra reads
        run_byte(8'h00, 1, 0);     // R5 all-zero byte
        run_byte(8'hFF, 7, 1);     // R7 R8
        run_byte(8'h5A, CAP, 1);   // R6 boundary: match on last allowed pulse
        run_byte(8'h81, 0, 0);     // R6 never matches
        run_byte(8'h42, 2, 0);     // R10 restart after fail
        chk(sb_q.size() == 0, "R5 all results seen", sb_q.size(), 0);
        finish_run();
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

endmodule